// File: doc/BRIEF.md
# MAC Pause Quanta Timer

This block stalls a MAC transmitter for the span requested by a received flow-control frame. The receive path, once it has validated such a frame, presents the 16-bit quanta value with a one-cycle strobe. The block loads that value into a down-counter and keeps a transmit-hold output high for as long as the counter is nonzero. Each quantum lasts 512 bit times. On a 4-bit-per-clock receive interface that is 128 receive clocks, so a small prescaler produces the decrement tick.

A test input shortens each quantum to a single clock, so that the whole pause span can be exercised quickly. A pause-enable input gates the whole function. With enable low, strobes are ignored, any pending pause is dropped, and the hold output is low. A fresh strobe while a pause is running replaces the remaining count. A strobed value of zero ends the pause. The remaining count is also brought out so that the transmit side can observe it.

Top module: `pause_quanta_timer`

## Requirements
- R1: A strobe on `frame_pause_vld` is accepted only while `flow_ctrl_en` is 1. A strobe while `flow_ctrl_en` is 0 leaves `quanta_left` at 0 and `tx_hold` at 0.
- R2: `tx_hold` is 1 exactly when `flow_ctrl_en` is 1 and `quanta_left` is nonzero. It follows `flow_ctrl_en` in the same cycle, with no register between them.
- R3: With `quantum_fast` = 0, `quanta_left` drops by one every 128 clocks. The first drop comes on the 128th rising edge after the edge that loaded the value.
- R4: With `quantum_fast` = 1, `quanta_left` drops by one on every rising edge while it is nonzero.
- R5: An accepted strobe while the count is running loads the new value on the next edge. The load takes priority over a decrement on that edge and restarts the 128-clock interval.
- R6: An accepted strobe carrying value 0 sets `quanta_left` to 0 on the next edge, and `tx_hold` falls with it.
- R7: While `flow_ctrl_en` is 0, `quanta_left` becomes 0 on the next rising edge. A pause that is cut this way does not resume when enable returns.
- R8: Once at 0, `quanta_left` stays at 0 until a strobe is accepted. It never wraps to the maximum value.
- R9: While `rst_n` is low, `quanta_left` is 0 and `tx_hold` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flow_ctrl_en | input | 1 | Enables pausing; 0 drops any pause |
| quantum_fast | input | 1 | 1: one quantum per clock (test) |
| frame_pause_vld | input | 1 | One-cycle strobe for a validated pause frame |
| frame_pause_quanta | input | 16 | Pause length in quanta, sampled with the strobe |
| tx_hold | output | 1 | Hold off transmission |
| quanta_left | output | 16 | Remaining pause quanta |

## Verification
The bench builds the block with its default parameters: 16-bit quanta and a 7-bit prescaler, which gives 128 clocks per quantum. These values reach the exact 128-edge boundary of the first and later decrements in normal mode. They also reach the full 65535-quanta load, which the bench drains in fast mode in about 65 thousand clocks. On every clock a behavioural model with integer state is compared against both outputs. The stimulus covers reloads, zero loads, enable drops and switches of the quantum speed during a running pause.

// File: rtl/pause_pkg.sv
package pause_pkg;
    localparam int unsigned QUANTA_W_DEF   = 16;
    localparam int unsigned PRESCALE_W_DEF = 7;

    typedef enum logic [1:0] {
        CNT_IDLE,
        CNT_LOAD,
        CNT_STEP,
        CNT_HOLD
    } cnt_action_e;
endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
    parameter int unsigned PRESCALE_W = pause_pkg::PRESCALE_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic fast,
    output logic tick
);
    generate
        if (PRESCALE_W == 0) begin : g_nodiv
            assign tick = run;
        end else begin : g_div
            localparam logic [PRESCALE_W-1:0] PRE_LAST = {PRESCALE_W{1'b1}};

            typedef struct packed {
                logic [PRESCALE_W-1:0] pre;
            } pre_state_t;

            pre_state_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (restart || !run) begin
                    st_d.pre = '0;
                end else begin
                    st_d.pre = st_q.pre + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign tick = run && !restart && (fast || (st_q.pre == PRE_LAST));

            // R3: a restart must leave the interval counter at zero
            assert_pre_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> (st_q.pre == '0));
        end
    endgenerate
endmodule

// File: rtl/pause_counter.sv
module pause_counter #(
    parameter int unsigned QUANTA_W = pause_pkg::QUANTA_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                load,
    input  logic [QUANTA_W-1:0] load_val,
    input  logic                tick,
    output logic [QUANTA_W-1:0] count,
    output logic                active
);
    import pause_pkg::*;

    typedef struct packed {
        logic [QUANTA_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t  st_d, st_q;
    cnt_action_e act;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            act = CNT_IDLE;
        end else if (load) begin
            act = CNT_LOAD;
        end else if (st_q.cnt != '0 && tick) begin
            act = CNT_STEP;
        end else begin
            act = CNT_HOLD;
        end
        case (act)
            CNT_IDLE: st_d.cnt = '0;
            CNT_LOAD: st_d.cnt = load_val;
            CNT_STEP: st_d.cnt = st_q.cnt - 1'b1;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.cnt;
    assign active = (st_q.cnt != '0);

    // R5/R6: an accepted load lands exactly on the next edge
    assert_load_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load) |=> (st_q.cnt == $past(load_val)));

    // R8: zero is sticky without a load
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !(enable && load)) |=> (st_q.cnt == '0));

    // R3: without a load the count moves by at most one
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !load && st_q.cnt != '0) |=>
        (st_q.cnt == $past(st_q.cnt) || st_q.cnt == QUANTA_W'($past(st_q.cnt) - 1'b1)));

    // R7: enable low drops the pause on the next edge
    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q.cnt == '0));
endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer #(
    parameter int unsigned QUANTA_W   = pause_pkg::QUANTA_W_DEF,
    parameter int unsigned PRESCALE_W = pause_pkg::PRESCALE_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flow_ctrl_en,
    input  logic                quantum_fast,
    input  logic                frame_pause_vld,
    input  logic [QUANTA_W-1:0] frame_pause_quanta,
    output logic                tx_hold,
    output logic [QUANTA_W-1:0] quanta_left
);
    logic load_acc;
    logic restart;
    logic tick;
    logic active;

    assign load_acc = frame_pause_vld && flow_ctrl_en;
    assign restart  = load_acc || !flow_ctrl_en;

    pause_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .run     (active),
        .fast    (quantum_fast),
        .tick    (tick)
    );

    pause_counter #(.QUANTA_W(QUANTA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (flow_ctrl_en),
        .load     (load_acc),
        .load_val (frame_pause_quanta),
        .tick     (tick),
        .count    (quanta_left),
        .active   (active)
    );

    assign tx_hold = flow_ctrl_en && active;

    // R4: fast quanta step the count on every edge
    assert_fast_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quantum_fast && flow_ctrl_en && !frame_pause_vld && quanta_left != '0) |=>
        (quanta_left == QUANTA_W'($past(quanta_left) - 1'b1)));

    // R1: a strobe while disabled leaves nothing behind
    assert_ignore_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_ctrl_en && frame_pause_vld) |=> (quanta_left == '0));
endmodule

// File: tb/pause_quanta_timer_bench.sv
module pause_quanta_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flow_ctrl_en = 1'b0;
    logic        quantum_fast = 1'b0;
    logic        frame_pause_vld = 1'b0;
    logic [15:0] frame_pause_quanta = '0;
    logic        tx_hold;
    logic [15:0] quanta_left;

    int compared = 0;
    int mismatched = 0;
    int m_cnt = 0;
    int m_pre = 0;
    string phase = "R9";
    bit done = 0;

    always #10 clk = ~clk;

    pause_quanta_timer u_pause_quanta_timer (
        .clk(clk), .rst_n(rst_n), .flow_ctrl_en(flow_ctrl_en),
        .quantum_fast(quantum_fast), .frame_pause_vld(frame_pause_vld),
        .frame_pause_quanta(frame_pause_quanta),
        .tx_hold(tx_hold), .quanta_left(quanta_left)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_pre = 0;
        end else if (!flow_ctrl_en) begin
            m_cnt = 0;
            m_pre = 0;
        end else if (frame_pause_vld) begin
            m_cnt = frame_pause_quanta;
            m_pre = 0;
        end else if (m_cnt != 0) begin
            if (quantum_fast || m_pre == 127) m_cnt = m_cnt - 1;
            m_pre = (m_pre + 1) % 128;
        end else begin
            m_pre = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            check({phase, " count"}, int'(quanta_left), m_cnt);
            check({phase, " hold"}, int'(tx_hold),
                  (flow_ctrl_en && m_cnt != 0) ? 1 : 0);
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe(input int q);
        frame_pause_vld = 1'b1;
        frame_pause_quanta = 16'(q);
        edges(1);
        frame_pause_vld = 1'b0;
    endtask

    initial begin
        #1;
        edges(3);
        check("R9 reset count", int'(quanta_left), 0);
        check("R9 reset hold", int'(tx_hold), 0);
        rst_n = 1'b1;
        edges(2);

        phase = "R1";
        strobe(9);
        check("R1 ignored count", int'(quanta_left), 0);
        check("R1 ignored hold", int'(tx_hold), 0);

        phase = "R3";
        flow_ctrl_en = 1'b1;
        edges(1);
        strobe(3);
        check("R2 hold after load", int'(tx_hold), 1);
        edges(127);
        check("R3 before first step", int'(quanta_left), 3);
        edges(1);
        check("R3 first step", int'(quanta_left), 2);
        edges(128);
        check("R3 second step", int'(quanta_left), 1);
        edges(128);
        check("R3 reaches zero", int'(quanta_left), 0);
        check("R2 hold released", int'(tx_hold), 0);
        edges(300);
        check("R8 stays zero", int'(quanta_left), 0);

        phase = "R5";
        strobe(4);
        edges(60);
        strobe(7);
        check("R5 reload value", int'(quanta_left), 7);
        edges(127);
        check("R5 interval restarted", int'(quanta_left), 7);
        edges(1);
        check("R5 step after reload", int'(quanta_left), 6);

        phase = "R6";
        strobe(0);
        check("R6 zero load", int'(quanta_left), 0);
        check("R6 hold low", int'(tx_hold), 0);

        phase = "R4";
        quantum_fast = 1'b1;
        strobe(10);
        edges(4);
        check("R4 fast steps", int'(quanta_left), 6);
        quantum_fast = 1'b0;
        edges(50);
        quantum_fast = 1'b1;
        edges(20);
        check("R4 fast drain", int'(quanta_left), 0);

        phase = "R7";
        quantum_fast = 1'b0;
        strobe(20);
        edges(10);
        #5;
        flow_ctrl_en = 1'b0;
        #1;
        check("R2/R7 hold drops same cycle", int'(tx_hold), 0);
        edges(1);
        check("R7 count cleared", int'(quanta_left), 0);
        flow_ctrl_en = 1'b1;
        edges(5);
        check("R7 no resume", int'(quanta_left), 0);

        phase = "R4 max";
        quantum_fast = 1'b1;
        strobe(65535);
        check("R4 max load", int'(quanta_left), 65535);
        edges(65535);
        check("R8 max drained", int'(quanta_left), 0);
        edges(5);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule